// File: doc/BRIEF.md
# Byte-Stuffed Frame Codec with Fletcher-16 Check

This block frames packets for a byte-wide link between two units and takes them apart again. The transmit half takes a packet as a stream of bytes, the last one marked. It opens the frame with a flag byte and replaces every reserved byte inside the frame with an escape pair. It then appends a two-byte Fletcher-16 check and closes with a second flag. The receive half searches for flags and removes escape pairs. It holds back the last two decoded bytes of each frame as the check. It delivers the remaining bytes with first and last markers and a good/bad status on the last byte.

The check covers the first `HDR_BYTES` bytes of each packet, or every byte when the packet is shorter than that. Both halves use valid/ready handshakes on every side. The receiver raises a one-cycle error pulse for each malformed frame, including frames too short to deliver any byte.

Transmit states: `T_IDLE` (waiting; moves to `T_DATA` when it emits the opening flag), `T_DATA` (accepts packet bytes; moves to `T_ESC` on a reserved byte, or to `T_CK0` after the last byte), `T_ESC` (emits the second byte of an escape pair, then returns to the remembered state), `T_CK0` / `T_CK1` (emit the low and then the high check byte, each escaped if needed), `T_CLOSE` (emits the closing flag and returns to `T_IDLE`). Receive states: `R_HUNT` (discards bytes until a flag; moves to `R_DATA`), `R_DATA` (takes data bytes; a flag ends the frame, an escape moves to `R_ESC`), `R_ESC` (un-escapes the next byte and returns to `R_DATA`, or aborts the frame on a flag).

Top module: `frame_codec`

## Requirements
- R1: After reset, line_out_valid, tx_ready, rx_valid and rx_err are 0 and line_in_ready is 1.
- R2: Each transmitted packet appears on line_out_byte as 0x7E, the packet bytes in order, the low check byte, the high check byte, and a closing 0x7E.
- R3: On transmit, every 0x7E or 0x7D among the packet bytes or the check bytes is sent as 0x7D followed by that byte XOR 0x20.
- R4: In the cycle after tx_ready accepts a 0x7E or 0x7D, tx_ready is 0 while the escaped byte is being emitted.
- R5: The check is Fletcher-16 with both sums starting at zero and modulo 255. The low byte is the running byte sum and the high byte is the sum of sums. It covers the first HDR_BYTES packet bytes, or all of them if the packet is shorter.
- R6: While line_out_valid is 1 and line_out_ready is 0, line_out_byte and line_out_valid hold.
- R7: The receiver ignores bytes before the first 0x7E. Two flags with nothing between them produce no output and no error.
- R8: For a frame with a correct check and at least HDR_BYTES+2 decoded bytes, the receiver delivers every decoded byte except the last two. It marks rx_first on the first byte, and rx_last and rx_good on the last. rx_err stays 0.
- R9: A frame whose check does not match is delivered with rx_good 0 on its last byte, and rx_err pulses once.
- R10: A frame with fewer than HDR_BYTES+2 decoded bytes is bad and pulses rx_err once. With only one or two decoded bytes, nothing is delivered.
- R11: 0x7D followed by 0x7E aborts the frame. Bytes already held back are delivered with rx_last set and rx_good 0, and rx_err pulses once if the frame had any byte.
- R12: While rx_valid is 1 and rx_ready is 0, rx outputs hold and line_in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_byte | input | 8 | Packet byte to transmit |
| tx_valid | input | 1 | tx_byte is valid |
| tx_last | input | 1 | tx_byte is the last byte of its packet |
| tx_ready | output | 1 | Transmitter accepts tx_byte |
| line_out_byte | output | 8 | Encoded line byte |
| line_out_valid | output | 1 | line_out_byte is valid |
| line_out_ready | input | 1 | Line side accepts line_out_byte |
| line_in_byte | input | 8 | Received line byte |
| line_in_valid | input | 1 | line_in_byte is valid |
| line_in_ready | output | 1 | Receiver accepts line_in_byte |
| rx_byte | output | 8 | Decoded packet byte |
| rx_valid | output | 1 | rx_byte is valid |
| rx_ready | input | 1 | Consumer accepts rx_byte |
| rx_first | output | 1 | rx_byte is the first byte of a packet |
| rx_last | output | 1 | rx_byte is the last byte of a packet |
| rx_good | output | 1 | Packet check passed (meaningful with rx_last) |
| rx_err | output | 1 | One-cycle pulse per bad or aborted frame |

## Verification
Transmit packets range from plain bytes to packets full of reserved bytes. One single-byte packet and one two-byte packet have check bytes that themselves need escaping. Together these separate data escaping from check escaping and header-limited summing from whole-packet summing. One packet is sent with line stall so the hold behaviour is exercised. The receive side gets leading garbage, good frames of header-only and longer length, and a corrupted check. It also gets frames of one, two and four bytes, aborts with and without held bytes, and a long frame under consumer stall. These show the hold-back of the check bytes, the length rule and the abort flush apart from one another.

// File: rtl/codec_pkg.sv
`timescale 1ns/1ps
package codec_pkg;
    localparam logic [7:0] FLAG_BYTE = 8'h7E;
    localparam logic [7:0] ESC_BYTE  = 8'h7D;
    localparam logic [7:0] ESC_MASK  = 8'h20;

    typedef enum logic [2:0] {T_IDLE, T_DATA, T_ESC, T_CK0, T_CK1, T_CLOSE} tx_st_t;
    typedef enum logic [1:0] {R_HUNT, R_DATA, R_ESC} rx_st_t;

    function automatic logic [7:0] add255(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 9'd255) s = s - 9'd255;
        return s[7:0];
    endfunction

    function automatic logic is_reserved(input logic [7:0] b);
        return (b == FLAG_BYTE) || (b == ESC_BYTE);
    endfunction
endpackage

// File: rtl/frame_tx.sv
`timescale 1ns/1ps
module frame_tx import codec_pkg::*; #(
    parameter int HDR_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_eop,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready
);
    localparam int IDX_W = $clog2(HDR_BYTES + 1);
    localparam logic [IDX_W-1:0] HDR_IDX = IDX_W'(HDR_BYTES);

    tx_st_t st, st_n, ret, ret_n, nx;
    logic [7:0] escb, escb_n, lo, lo_n, hi, hi_n, od, od_n, ck;
    logic [IDX_W-1:0] idx, idx_n;
    logic ov, ov_n, go;

    assign out_data  = od;
    assign out_valid = ov;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= T_IDLE; ret <= T_DATA; escb <= '0;
            lo <= '0; hi <= '0; idx <= '0; od <= '0; ov <= 1'b0;
        end else begin
            st <= st_n; ret <= ret_n; escb <= escb_n;
            lo <= lo_n; hi <= hi_n; idx <= idx_n; od <= od_n; ov <= ov_n;
        end
    end

    always_comb begin
        st_n = st; ret_n = ret; escb_n = escb; lo_n = lo; hi_n = hi;
        idx_n = idx; od_n = od;
        go = !ov || out_ready;
        ov_n = go ? 1'b0 : ov;
        in_ready = (st == T_DATA) && go;
        ck = lo;
        nx = T_CK1;
        unique case (st)
            T_IDLE: if (in_valid && go) begin
                od_n = FLAG_BYTE; ov_n = 1'b1; st_n = T_DATA;
                lo_n = '0; hi_n = '0; idx_n = '0;
            end
            T_DATA: if (in_valid && go) begin
                if (idx < HDR_IDX) begin
                    lo_n  = add255(lo, in_data);
                    hi_n  = add255(hi, lo_n);
                    idx_n = idx + IDX_W'(1);
                end
                ov_n = 1'b1;
                if (is_reserved(in_data)) begin
                    od_n = ESC_BYTE; escb_n = in_data ^ ESC_MASK;
                    ret_n = in_eop ? T_CK0 : T_DATA;
                    st_n = T_ESC;
                end else begin
                    od_n = in_data;
                    st_n = in_eop ? T_CK0 : T_DATA;
                end
            end
            T_ESC: if (go) begin
                od_n = escb; ov_n = 1'b1; st_n = ret;
            end
            T_CK0, T_CK1: if (go) begin
                ck = (st == T_CK0) ? lo : hi;
                nx = (st == T_CK0) ? T_CK1 : T_CLOSE;
                ov_n = 1'b1;
                if (is_reserved(ck)) begin
                    od_n = ESC_BYTE; escb_n = ck ^ ESC_MASK; ret_n = nx; st_n = T_ESC;
                end else begin
                    od_n = ck; st_n = nx;
                end
            end
            T_CLOSE: if (go) begin
                od_n = FLAG_BYTE; ov_n = 1'b1; st_n = T_IDLE;
            end
            default: st_n = T_IDLE;
        endcase
    end

    AST_TX_ESC_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && is_reserved(in_data)) |=> (!in_ready && out_valid && out_data == ESC_BYTE)); // R4
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
    AST_TX_AFTER_ESC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_data == ESC_BYTE) |=> (out_valid && !is_reserved(out_data))); // R3
endmodule

// File: rtl/frame_rx.sv
`timescale 1ns/1ps
module frame_rx import codec_pkg::*; #(
    parameter int HDR_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_sop,
    output logic       out_eop,
    output logic       out_good,
    output logic       err
);
    localparam int CNT_W = $clog2(HDR_BYTES + 3);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(HDR_BYTES + 2);
    localparam logic [CNT_W-1:0] CNT_HDR   = CNT_W'(HDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_THREE = CNT_W'(3);

    rx_st_t st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [7:0] lo, lo_n, hi, hi_n, h0, h0_n, h1, h1_n, h2, h2_n, od, od_n, b;
    logic ov, ov_n, sop, sop_n, eop, eop_n, good, good_n, first, first_n, err_r, err_n;
    logic take, fin, abort_f, start, bad;

    assign in_ready = !ov || out_ready;
    assign out_data = od;
    assign out_valid = ov;
    assign out_sop = sop;
    assign out_eop = eop;
    assign out_good = good;
    assign err = err_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= R_HUNT; cnt <= '0; lo <= '0; hi <= '0;
            h0 <= '0; h1 <= '0; h2 <= '0; od <= '0;
            ov <= 1'b0; sop <= 1'b0; eop <= 1'b0; good <= 1'b0;
            first <= 1'b1; err_r <= 1'b0;
        end else begin
            st <= st_n; cnt <= cnt_n; lo <= lo_n; hi <= hi_n;
            h0 <= h0_n; h1 <= h1_n; h2 <= h2_n; od <= od_n;
            ov <= ov_n; sop <= sop_n; eop <= eop_n; good <= good_n;
            first <= first_n; err_r <= err_n;
        end
    end

    always_comb begin
        st_n = st; cnt_n = cnt; lo_n = lo; hi_n = hi;
        h0_n = h0; h1_n = h1; h2_n = h2; od_n = od;
        sop_n = sop; eop_n = eop; good_n = good; first_n = first;
        ov_n = (ov && out_ready) ? 1'b0 : ov;
        err_n = 1'b0;
        take = 1'b0; fin = 1'b0; abort_f = 1'b0; start = 1'b0; bad = 1'b0;
        b = in_data;
        if (in_valid && in_ready) begin
            unique case (st)
                R_HUNT: if (in_data == FLAG_BYTE) begin
                    start = 1'b1; st_n = R_DATA;
                end
                R_DATA: begin
                    if (in_data == FLAG_BYTE) fin = 1'b1;
                    else if (in_data == ESC_BYTE) st_n = R_ESC;
                    else take = 1'b1;
                end
                R_ESC: begin
                    st_n = R_DATA;
                    if (in_data == FLAG_BYTE) begin
                        fin = 1'b1; abort_f = 1'b1;
                    end else begin
                        take = 1'b1; b = in_data ^ ESC_MASK;
                    end
                end
                default: st_n = R_HUNT;
            endcase
        end
        if (take) begin
            if (cnt >= CNT_THREE) begin
                od_n = h2; sop_n = first; eop_n = 1'b0; good_n = 1'b0;
                ov_n = 1'b1; first_n = 1'b0;
            end
            h2_n = h1; h1_n = h0; h0_n = b;
            if (cnt < CNT_HDR) begin
                lo_n = add255(lo, b);
                hi_n = add255(hi, lo_n);
            end
            if (cnt != CNT_FULL) cnt_n = cnt + CNT_W'(1);
        end
        if (fin) begin
            bad = abort_f || (cnt < CNT_FULL) || (h1 != lo) || (h0 != hi);
            if (cnt >= CNT_THREE) begin
                od_n = h2; sop_n = first; eop_n = 1'b1; good_n = !bad; ov_n = 1'b1;
            end
            if (cnt != '0) err_n = bad;
        end
        if (fin || start) begin
            cnt_n = '0; lo_n = '0; hi_n = '0; first_n = 1'b1;
        end
    end

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop) && $stable(out_good))); // R12
    AST_RX_GOOD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_good) |-> out_eop); // R8
    AST_RX_ERR_NOT_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !(out_valid && out_good)); // R9
    AST_RX_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R10
endmodule

// File: rtl/frame_codec.sv
`timescale 1ns/1ps
module frame_codec #(
    parameter int HDR_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_byte,
    input  logic       tx_valid,
    input  logic       tx_last,
    output logic       tx_ready,
    output logic [7:0] line_out_byte,
    output logic       line_out_valid,
    input  logic       line_out_ready,
    input  logic [7:0] line_in_byte,
    input  logic       line_in_valid,
    output logic       line_in_ready,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    input  logic       rx_ready,
    output logic       rx_first,
    output logic       rx_last,
    output logic       rx_good,
    output logic       rx_err
);
    frame_tx #(.HDR_BYTES(HDR_BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .in_data(tx_byte), .in_valid(tx_valid), .in_eop(tx_last), .in_ready(tx_ready),
        .out_data(line_out_byte), .out_valid(line_out_valid), .out_ready(line_out_ready)
    );

    frame_rx #(.HDR_BYTES(HDR_BYTES)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_data(line_in_byte), .in_valid(line_in_valid), .in_ready(line_in_ready),
        .out_data(rx_byte), .out_valid(rx_valid), .out_ready(rx_ready),
        .out_sop(rx_first), .out_eop(rx_last), .out_good(rx_good), .err(rx_err)
    );
endmodule

// File: tb/tb_frame_codec.sv
`timescale 1ns/1ps
module tb_frame_codec;
    localparam int HDR = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic [7:0] tx_byte = '0;
    logic tx_valid = 1'b0, tx_last = 1'b0, tx_ready;
    logic [7:0] line_out_byte;
    logic line_out_valid, line_out_ready = 1'b1;
    logic [7:0] line_in_byte = '0;
    logic line_in_valid = 1'b0, line_in_ready;
    logic [7:0] rx_byte;
    logic rx_valid, rx_ready = 1'b1, rx_first, rx_last, rx_good, rx_err;

    frame_codec #(.HDR_BYTES(HDR)) dut (
        .clk(clk), .rst_n(rst_n),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .line_out_byte(line_out_byte), .line_out_valid(line_out_valid), .line_out_ready(line_out_ready),
        .line_in_byte(line_in_byte), .line_in_valid(line_in_valid), .line_in_ready(line_in_ready),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_first(rx_first), .rx_last(rx_last), .rx_good(rx_good), .rx_err(rx_err)
    );

    int n_checks = 0, n_fail = 0;
    logic [7:0]  exp_line[$];
    logic [10:0] exp_rx[$];
    int exp_err = 0, err_seen = 0;
    bit [7:0] pkt[64];
    int plen = 0;
    bit bp_tx = 0, bp_rx = 0;
    int cyc = 0;
    string rx_tag = "R8";
    bit stall_prev = 0;
    logic [7:0] stall_byte = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fl16(input int n);
        int lo = 0, hi = 0;
        for (int i = 0; i < n; i++) begin
            lo = (lo + pkt[i]) % 255;
            hi = (hi + lo) % 255;
        end
        return {hi[7:0], lo[7:0]};
    endfunction

    function automatic bit resv(input logic [7:0] b);
        return (b == 8'h7E) || (b == 8'h7D);
    endfunction

    task automatic push_stuffed(input logic [7:0] b);
        if (resv(b)) begin exp_line.push_back(8'h7D); exp_line.push_back(b ^ 8'h20); end
        else exp_line.push_back(b);
    endtask

    // stall pattern generators
    always begin
        @(posedge clk); #1;
        cyc++;
        line_out_ready = bp_tx ? (cyc % 3 != 0) : 1'b1;
        rx_ready       = bp_rx ? (cyc % 4 >= 2) : 1'b1;
    end

    // line-side monitor for the transmitter
    always @(negedge clk) if (rst_n) begin
        if (stall_prev)
            check(line_out_valid && line_out_byte == stall_byte, "R6", line_out_byte, stall_byte);
        stall_prev = line_out_valid && !line_out_ready;
        stall_byte = line_out_byte;
        if (line_out_valid && line_out_ready) begin
            if (exp_line.size() == 0) check(0, "R2 (unexpected byte)", line_out_byte, 0);
            else begin
                logic [7:0] e;
                e = exp_line.pop_front();
                check(line_out_byte == e, "R2/R3/R5", line_out_byte, e);
            end
        end
    end

    // consumer-side monitor for the receiver
    always @(negedge clk) if (rst_n) begin
        if (rx_err) err_seen++;
        if (rx_valid && !rx_ready) check(!line_in_ready, "R12", line_in_ready, 0);
        if (rx_valid && rx_ready) begin
            if (exp_rx.size() == 0) check(0, rx_tag, {rx_first, rx_last, rx_good, rx_byte}, 0);
            else begin
                logic [10:0] e;
                e = exp_rx.pop_front();
                check({rx_first, rx_last, rx_good, rx_byte} == e, rx_tag,
                      {rx_first, rx_last, rx_good, rx_byte}, e);
            end
        end
    end

    task automatic tx_send();
        int n;
        logic [15:0] ck;
        n = (plen < HDR) ? plen : HDR;
        ck = fl16(n);
        exp_line.push_back(8'h7E);
        for (int i = 0; i < plen; i++) push_stuffed(pkt[i]);
        push_stuffed(ck[7:0]);
        push_stuffed(ck[15:8]);
        exp_line.push_back(8'h7E);
        for (int i = 0; i < plen; i++) begin
            tx_valid = 1'b1; tx_byte = pkt[i]; tx_last = (i == plen - 1);
            do @(negedge clk); while (!tx_ready);
            @(posedge clk); #1;
            tx_valid = 1'b0; tx_last = 1'b0;
            if (resv(pkt[i])) begin
                @(negedge clk);
                check(!tx_ready, "R4", tx_ready, 0);
            end
        end
        for (int k = 0; k < 200 && exp_line.size() != 0; k++) @(negedge clk);
        check(exp_line.size() == 0, "R2", exp_line.size(), 0);
    endtask

    task automatic rx_send_byte(input logic [7:0] b);
        line_in_valid = 1'b1; line_in_byte = b;
        do @(negedge clk); while (!line_in_ready);
        @(posedge clk); #1;
        line_in_valid = 1'b0;
    endtask

    task automatic mk_good(input int n, input int seed);
        logic [15:0] ck;
        for (int i = 0; i < n; i++) pkt[i] = 8'(seed + i * 29);
        ck = fl16(HDR);
        pkt[n] = ck[7:0]; pkt[n + 1] = ck[15:8];
        plen = n + 2;
    endtask

    task automatic rx_frame(input bit abort_it);
        bit ok;
        logic [15:0] ck;
        ok = !abort_it && plen >= HDR + 2;
        if (plen >= HDR + 2) begin
            ck = fl16(HDR);
            ok = ok && pkt[plen - 2] == ck[7:0] && pkt[plen - 1] == ck[15:8];
        end
        if (plen >= 3)
            for (int i = 0; i < plen - 2; i++)
                exp_rx.push_back({(i == 0), (i == plen - 3), (i == plen - 3) && ok, pkt[i]});
        if (!ok && plen > 0) exp_err++;
        rx_send_byte(8'h7E);
        for (int i = 0; i < plen; i++) begin
            if (resv(pkt[i])) begin rx_send_byte(8'h7D); rx_send_byte(pkt[i] ^ 8'h20); end
            else rx_send_byte(pkt[i]);
        end
        if (abort_it) rx_send_byte(8'h7D);
        rx_send_byte(8'h7E);
    endtask

    task automatic rx_drain(input string req);
        repeat (30) @(negedge clk);
        check(exp_rx.size() == 0, req, exp_rx.size(), 0);
        check(err_seen == exp_err, req, err_seen, exp_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!line_out_valid, "R1", line_out_valid, 0);
        check(!tx_ready, "R1", tx_ready, 0);
        check(!rx_valid, "R1", rx_valid, 0);
        check(!rx_err, "R1", rx_err, 0);
        check(line_in_ready, "R1", line_in_ready, 1);

        // R2/R5: plain packet longer than the header
        for (int i = 0; i < 7; i++) pkt[i] = 8'(i + 1);
        plen = 7; tx_send();
        // R3/R4: reserved bytes inside header and payload
        pkt[0] = 8'h7E; pkt[1] = 8'h11; pkt[2] = 8'h7D; pkt[3] = 8'h22; pkt[4] = 8'h5D; pkt[5] = 8'h7E;
        plen = 6; tx_send();
        // R3/R5: one-byte packet, both check bytes equal 0x7E
        pkt[0] = 8'h7E; plen = 1; tx_send();
        // R5/R6: two-byte packet whose low check byte is 0x7E, sent under line stall
        bp_tx = 1;
        pkt[0] = 8'h3F; pkt[1] = 8'h3F; plen = 2; tx_send();
        for (int i = 0; i < 12; i++) pkt[i] = 8'(8'h70 + i);
        plen = 12; tx_send();
        bp_tx = 0;

        // R7: garbage before the first flag is dropped
        rx_tag = "R7";
        rx_send_byte(8'h11); rx_send_byte(8'h7D); rx_send_byte(8'h22);
        rx_tag = "R8";
        mk_good(6, 8'h50); pkt[1] = 8'h7E; pkt[4] = 8'h7D;
        begin logic [15:0] ck; ck = fl16(HDR); pkt[6] = ck[7:0]; pkt[7] = ck[15:8]; end
        rx_frame(0);
        rx_drain("R8");
        mk_good(4, 8'h10); rx_frame(0);
        mk_good(9, 8'h33); rx_frame(0);
        rx_drain("R8");

        // R9: corrupted check
        rx_tag = "R9";
        mk_good(7, 8'h21); pkt[plen - 1] = pkt[plen - 1] ^ 8'h01; rx_frame(0);
        rx_drain("R9");

        // R10: too-short frames
        rx_tag = "R10";
        pkt[0] = 8'hA1; pkt[1] = 8'hA2; plen = 2; rx_frame(0);
        pkt[0] = 8'hB1; pkt[1] = 8'hB2; pkt[2] = 8'hB3; pkt[3] = 8'hB4; plen = 4; rx_frame(0);
        rx_drain("R10");

        // R11: aborts with and without held bytes
        rx_tag = "R11";
        mk_good(5, 8'h61); rx_frame(1);
        pkt[0] = 8'hC5; plen = 1; rx_frame(1);
        rx_drain("R11");

        // R7: empty frames only
        rx_tag = "R7";
        rx_send_byte(8'h7E); rx_send_byte(8'h7E); rx_send_byte(8'h7E);
        rx_drain("R7");

        // R12: consumer stall
        rx_tag = "R12";
        bp_rx = 1;
        mk_good(10, 8'h05); rx_frame(0);
        mk_good(3, 8'h7C); rx_frame(0);
        rx_drain("R12");
        bp_rx = 0;

        repeat (5) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule